// File: doc/BRIEF.md
# Locked Read-Modify-Write Memory Unit

This unit performs one atomic memory operation at a time against a single-port memory bus that carries a lock line. A request names an operation, an operand width, a byte address, a source value and a compare value. The unit first waits until the surrounding memory pipeline reports that all earlier accesses have drained, so that each operation also acts as a full barrier. It then raises the lock and reads the addressed location. It computes the replacement value, writes it back when the operation calls for a write, and drops the lock.

The value that memory held before the operation is returned on a separate output. This lets the issuing core place it in a third result register, apart from the source and destination. Flags report a zero result, a compare match, or the prior state of a tested bit. Addresses that are not naturally aligned for the chosen width are rejected before any bus activity. Address generation and caching belong to the surrounding core.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, op_ready is 1 and mem_req, mem_lock and done are 0.
- R2: op_code selects 0 fetch-add, 1 fetch-subtract, 2 fetch-AND, 3 fetch-OR, 4 test-and-set bit, 5 test-and-clear bit, 6 compare-and-exchange and 7 swap. The value written back is that result truncated to the operand width.
- R3: In the done cycle, old_value holds the memory operand as read before modification, zero-extended from the operand width.
- R4: op_size 0/1/2/3 selects 8/16/32/64-bit operands. op_addr is a byte address, and mem_addr is op_addr with its low 3 bits cleared. The operand sits in byte lanes starting at op_addr[2:0] of the 64-bit bus (lane k = bits 8k+7:8k). On a write, mem_be sets exactly the bits of those lanes.
- R5: mem_lock is 1 during every bus request of an operation and stays 1 from the read request through the write acknowledge. It is 0 in the done cycle.
- R6: No read request is issued while drain_empty is 0; the operation waits and then proceeds.
- R7: A non-faulting operation issues exactly one read and at most one write, both to the same word address.
- R8: For bit operations, the bit index is op_src modulo the operand width. flag_bit returns the prior value of that bit, and flag_z is 1 when that prior bit was 0. flag_bit is 0 for all other operations.
- R9: Compare-and-exchange writes op_src only when the read operand equals op_cmp truncated to the operand width, and then sets flag_z to 1. On a mismatch it does no write, sets flag_z to 0 and releases the lock.
- R10: For add, subtract, AND, OR and swap, flag_z is 1 exactly when the value written is zero.
- R11: An address not a multiple of the operand byte count raises align_err with done in the cycle after acceptance, and no bus request is issued.
- R12: Once raised, mem_req stays high with mem_addr and mem_we unchanged until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit idle, request accepted this cycle |
| op_code | input | 3 | Atomic operation select |
| op_size | input | 2 | Operand width select |
| op_addr | input | ADDR_W | Byte address of the operand |
| op_src | input | 64 | Source operand or bit index |
| op_cmp | input | 64 | Compare value for compare-and-exchange |
| drain_empty | input | 1 | Earlier memory accesses have completed |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write (1) or read (0) |
| mem_lock | output | 1 | Bus lock held |
| mem_addr | output | ADDR_W | Word-aligned bus address |
| mem_wdata | output | 64 | Write data, operand placed in its lanes |
| mem_be | output | 8 | Byte enables for a write |
| mem_ack | input | 1 | Bus access completes this cycle |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | Alignment fault, valid with done |
| old_value | output | 64 | Prior memory operand, valid with done |
| flag_z | output | 1 | Zero / match / bit-was-clear flag, valid with done |
| flag_bit | output | 1 | Prior bit state for bit operations, valid with done |

## Verification
Results are due in the done cycle. That cycle is one clock after the write acknowledge, or two clocks after the read acknowledge when a compare-and-exchange misses. A rejected address gives done exactly one clock after acceptance. The bench drives inputs and samples outputs on falling edges. It polls done on falling edges and compares old_value, the flags and the memory image in that cycle only. Alignment faults are checked at the single falling edge where done must appear. The bus model checks lane enables, address stability and the lock at each acknowledge, with wait states of zero to two cycles. During a held drain it checks every cycle that no request or lock appears.

// File: rtl/atom_pkg.sv
package atom_pkg;

    localparam int DATA_W     = 64;
    localparam int LANES      = DATA_W / 8;
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int BIT_IDX_W  = $clog2(DATA_W);
    localparam int SIZE_W     = 2;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_BSET = 3'd4,
        OP_BCLR = 3'd5,
        OP_CMPX = 3'd6,
        OP_SWAP = 3'd7
    } atom_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DRAIN = 3'd1,
        ST_READ  = 3'd2,
        ST_CALC  = 3'd3,
        ST_WRITE = 3'd4,
        ST_DONE  = 3'd5
    } atom_st_e;

    // all-ones mask for the operand width
    function automatic logic [DATA_W-1:0] width_mask(input logic [SIZE_W-1:0] sz);
        case (sz)
            2'd0:    return DATA_W'(64'h0000_0000_0000_00FF);
            2'd1:    return DATA_W'(64'h0000_0000_0000_FFFF);
            2'd2:    return DATA_W'(64'h0000_0000_FFFF_FFFF);
            default: return '1;
        endcase
    endfunction

    // highest legal bit index for the operand width
    function automatic logic [BIT_IDX_W-1:0] bit_limit(input logic [SIZE_W-1:0] sz);
        case (sz)
            2'd0:    return BIT_IDX_W'(7);
            2'd1:    return BIT_IDX_W'(15);
            2'd2:    return BIT_IDX_W'(31);
            default: return BIT_IDX_W'(63);
        endcase
    endfunction

    // low address bits that must be zero for natural alignment
    function automatic logic [LANE_IDX_W-1:0] align_bits(input logic [SIZE_W-1:0] sz);
        case (sz)
            2'd0:    return LANE_IDX_W'(0);
            2'd1:    return LANE_IDX_W'(1);
            2'd2:    return LANE_IDX_W'(3);
            default: return LANE_IDX_W'(7);
        endcase
    endfunction

endpackage

// File: rtl/atom_lane.sv
module atom_lane
    import atom_pkg::*;
(
    input  logic [SIZE_W-1:0]     size,
    input  logic [LANE_IDX_W-1:0] offset,
    input  logic [DATA_W-1:0]     rd_word,
    input  logic [DATA_W-1:0]     wr_value,
    output logic [DATA_W-1:0]     rd_value,
    output logic [DATA_W-1:0]     wr_word,
    output logic [LANES-1:0]      byte_en
);
    localparam int CNT_W = LANE_IDX_W + 1;

    logic [DATA_W-1:0]     mask;
    logic [BIT_IDX_W-1:0]  shift;
    logic [CNT_W-1:0]      nbytes;
    logic [CNT_W-1:0]      first;

    assign mask     = width_mask(size);
    assign shift    = {offset, 3'b000};
    assign nbytes   = CNT_W'(1) << size;
    assign first    = {1'b0, offset};
    assign rd_value = (rd_word >> shift) & mask;
    assign wr_word  = (wr_value & mask) << shift;

    for (genvar i = 0; i < LANES; i++) begin : g_lane_en
        assign byte_en[i] = (CNT_W'(i) >= first) && (CNT_W'(i) < (first + nbytes));
    end

endmodule

// File: rtl/atom_alu.sv
module atom_alu
    import atom_pkg::*;
(
    input  atom_op_e          op,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] cmp,
    output logic [DATA_W-1:0] new_val,
    output logic              do_write,
    output logic              flag_z,
    output logic              flag_bit
);
    logic [DATA_W-1:0]    mask;
    logic [DATA_W-1:0]    raw;
    logic [DATA_W-1:0]    bit_sel;
    logic [BIT_IDX_W-1:0] bidx;
    logic                 match;
    logic                 is_bit;
    logic                 prior;

    always_comb begin
        mask    = width_mask(size);
        bidx    = src[BIT_IDX_W-1:0] & bit_limit(size);
        bit_sel = DATA_W'(1) << bidx;
        prior   = old_val[bidx];
        match   = (old_val == (cmp & mask));
        is_bit  = (op == OP_BSET) || (op == OP_BCLR);
        case (op)
            OP_ADD:  raw = old_val + src;
            OP_SUB:  raw = old_val - src;
            OP_AND:  raw = old_val & src;
            OP_OR:   raw = old_val | src;
            OP_BSET: raw = old_val | bit_sel;
            OP_BCLR: raw = old_val & ~bit_sel;
            default: raw = src;
        endcase
        new_val  = raw & mask;
        do_write = (op != OP_CMPX) || match;
        flag_bit = is_bit & prior;
        if (op == OP_CMPX)
            flag_z = match;
        else if (is_bit)
            flag_z = ~prior;
        else
            flag_z = (new_val == '0);
    end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atom_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [2:0]        op_code,
    input  logic [1:0]        op_size,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [63:0]       op_src,
    input  logic [63:0]       op_cmp,
    input  logic              drain_empty,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    output logic [7:0]        mem_be,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic              align_err,
    output logic [63:0]       old_value,
    output logic              flag_z,
    output logic              flag_bit
);
    typedef struct packed {
        atom_st_e            st;
        atom_op_e            op;
        logic [SIZE_W-1:0]   size;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   src;
        logic [DATA_W-1:0]   cmp;
        logic [DATA_W-1:0]   old;
        logic [DATA_W-1:0]   newv;
        logic                z;
        logic                bitp;
        logic                err;
    } ctx_t;

    ctx_t s_d, s_q;

    logic              misaligned;
    logic [DATA_W-1:0] lane_rd;
    logic [DATA_W-1:0] lane_wr;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] alu_new;
    logic              alu_wr;
    logic              alu_z;
    logic              alu_bit;

    assign misaligned = |(op_addr[LANE_IDX_W-1:0] & align_bits(op_size));

    atom_lane u_lane (
        .size     (s_q.size),
        .offset   (s_q.addr[LANE_IDX_W-1:0]),
        .rd_word  (mem_rdata),
        .wr_value (s_q.newv),
        .rd_value (lane_rd),
        .wr_word  (lane_wr),
        .byte_en  (lane_be)
    );

    atom_alu u_alu (
        .op       (s_q.op),
        .size     (s_q.size),
        .old_val  (s_q.old),
        .src      (s_q.src),
        .cmp      (s_q.cmp),
        .new_val  (alu_new),
        .do_write (alu_wr),
        .flag_z   (alu_z),
        .flag_bit (alu_bit)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (op_valid) begin
                    s_d.op   = atom_op_e'(op_code);
                    s_d.size = op_size;
                    s_d.addr = op_addr;
                    s_d.src  = op_src;
                    s_d.cmp  = op_cmp;
                    s_d.old  = '0;
                    s_d.newv = '0;
                    s_d.z    = 1'b0;
                    s_d.bitp = 1'b0;
                    s_d.err  = misaligned;
                    s_d.st   = misaligned ? ST_DONE : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (drain_empty) s_d.st = ST_READ;
            end
            ST_READ: begin
                if (mem_ack) begin
                    s_d.old = lane_rd;
                    s_d.st  = ST_CALC;
                end
            end
            ST_CALC: begin
                s_d.newv = alu_new;
                s_d.z    = alu_z;
                s_d.bitp = alu_bit;
                s_d.st   = alu_wr ? ST_WRITE : ST_DONE;
            end
            ST_WRITE: begin
                if (mem_ack) s_d.st = ST_DONE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign op_ready  = (s_q.st == ST_IDLE);
    assign mem_req   = (s_q.st == ST_READ) || (s_q.st == ST_WRITE);
    assign mem_we    = (s_q.st == ST_WRITE);
    assign mem_lock  = (s_q.st == ST_READ) || (s_q.st == ST_CALC) || (s_q.st == ST_WRITE);
    assign mem_addr  = {s_q.addr[ADDR_W-1:LANE_IDX_W], LANE_IDX_W'(0)};
    assign mem_wdata = lane_wr;
    assign mem_be    = lane_be;
    assign done      = (s_q.st == ST_DONE);
    assign align_err = s_q.err;
    assign old_value = s_q.old;
    assign flag_z    = s_q.z;
    assign flag_bit  = s_q.bitp;

    // R5: any bus request happens under the lock
    assert_req_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    // R5: the lock is gone by the completion pulse
    assert_unlock_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_lock);

    // R12: a pending request holds its address and direction
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6: no request while earlier accesses are outstanding
    assert_drain_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DRAIN && !drain_empty) |=> !mem_req);

    // R11: a misaligned request completes at once with an error and no bus cycle
    assert_align_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && misaligned) |=> (done && align_err && !mem_req));

    // R9: compare-and-exchange writes only after a match
    assert_cmpx_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_req && s_q.op == OP_CMPX) |-> s_q.z);

    // R4: the write lane count equals the operand byte count
    assert_lane_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == (1 << s_q.size)));

endmodule

// File: tb/atomic_rmw_unit_tb.sv
module atomic_rmw_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic        op_ready;
    logic [2:0]  op_code;
    logic [1:0]  op_size;
    logic [15:0] op_addr;
    logic [63:0] op_src;
    logic [63:0] op_cmp;
    logic        drain_empty;
    logic        mem_req;
    logic        mem_we;
    logic        mem_lock;
    logic [15:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_be;
    logic        mem_ack;
    logic [63:0] mem_rdata;
    logic        done;
    logic        align_err;
    logic [63:0] old_value;
    logic        flag_z;
    logic        flag_bit;

    always #5 clk = ~clk;

    atomic_rmw_unit #(.ADDR_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
        .op_size(op_size), .op_addr(op_addr), .op_src(op_src), .op_cmp(op_cmp),
        .drain_empty(drain_empty),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .align_err(align_err), .old_value(old_value),
        .flag_z(flag_z), .flag_bit(flag_bit)
    );

    logic [63:0] mem_arr [0:15];
    int          checks = 0;
    int          errors = 0;
    int          rd_cnt;
    int          wr_cnt;
    int          lat;
    int          wait_cnt;
    logic [15:0] first_addr;
    logic [15:0] exp_waddr;
    logic [7:0]  exp_be;
    bit          finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mix(input int n);
        logic [63:0] x;
        x = (64'(n) * 64'h9E37_79B9_7F4A_7C15) ^ 64'hA5A5_0F0F_3C3C_5A5A;
        x = x ^ (x >> 29);
        x = x * 64'hBF58_476D_1CE4_E5B9;
        return x ^ (x >> 31);
    endfunction

    // bus model: acknowledges after lat wait cycles, checks lanes, address and lock
    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        wait_cnt  = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack  = 1'b0;
                wait_cnt = 0;
            end else if (mem_req) begin
                if (wait_cnt == 0) first_addr = mem_addr;
                if (wait_cnt >= lat) begin
                    chk(mem_addr == first_addr, "R12 address held", 64'(mem_addr), 64'(first_addr));
                    chk(mem_addr == exp_waddr, "R4 word address", 64'(mem_addr), 64'(exp_waddr));
                    chk(mem_lock == 1'b1, "R5 lock at access", 64'(mem_lock), 64'd1);
                    if (mem_we) begin
                        chk(mem_be == exp_be, "R4 byte enables", 64'(mem_be), 64'(exp_be));
                        for (int b = 0; b < 8; b++)
                            if (mem_be[b]) mem_arr[mem_addr[6:3]][b*8 +: 8] = mem_wdata[b*8 +: 8];
                        wr_cnt++;
                    end else begin
                        mem_rdata = mem_arr[mem_addr[6:3]];
                        rd_cnt++;
                    end
                    mem_ack = 1'b1;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic issue(input int op, input int sz, input logic [15:0] addr,
                         input logic [63:0] src, input logic [63:0] cmp, input int hold);
        rd_cnt = 0;
        wr_cnt = 0;
        @(negedge clk);
        op_code  = 3'(op);
        op_size  = 2'(sz);
        op_addr  = addr;
        op_src   = src;
        op_cmp   = cmp;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        if (hold > 0) begin
            for (int h = 0; h < hold; h++) begin
                chk(!mem_req && !mem_lock, "R6 waits for drain", 64'({mem_req, mem_lock}), 64'd0);
                @(negedge clk);
            end
            drain_empty = 1'b1;
        end
        for (int w = 0; w < 100 && !done; w++) @(negedge clk);
        chk(done, "R7 completion", 64'(done), 64'd1);
    endtask

    task automatic run_rmw(input int n, input int op, input int sz, input int off, input int p, input int hold);
        logic [63:0] mask, w, old_s, src, cmp, nv, exp_word;
        int          sh, idx, widx;
        bit          wr, ez, eb, isbit;
        widx  = n % 16;
        w     = mix(n);
        mem_arr[widx] = w;
        mask  = (sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
        sh    = off * 8;
        old_s = (w >> sh) & mask;
        src   = (p == 2) ? (~old_s + 64'd1) : mix(n + 7777);
        cmp   = (p == 0) ? old_s : (old_s ^ 64'd1);
        idx   = int'(src[5:0]) % (8 << sz);
        isbit = (op == 4) || (op == 5);
        case (op)
            0: nv = old_s + src;
            1: nv = old_s - src;
            2: nv = old_s & src;
            3: nv = old_s | src;
            4: nv = old_s | (64'd1 << idx);
            5: nv = old_s & ~(64'd1 << idx);
            default: nv = src;
        endcase
        nv = nv & mask;
        wr = (op != 6) || (old_s == (cmp & mask));
        eb = isbit ? old_s[idx] : 1'b0;
        if (op == 6)      ez = (old_s == (cmp & mask));
        else if (isbit)   ez = ~old_s[idx];
        else              ez = (nv == 64'd0);
        exp_word  = wr ? ((w & ~(mask << sh)) | (nv << sh)) : w;
        exp_waddr = 16'(widx * 8);
        exp_be    = 8'(((1 << (1 << sz)) - 1) << off);
        lat       = n % 3;
        if (hold > 0) drain_empty = 1'b0;
        issue(op, sz, exp_waddr + 16'(off), src, cmp, hold);
        chk(old_value == old_s, "R3 prior value", old_value, old_s);
        chk(flag_bit == eb, "R8 prior bit", 64'(flag_bit), 64'(eb));
        if (op == 6)     chk(flag_z == ez, "R9 match flag", 64'(flag_z), 64'(ez));
        else if (isbit)  chk(flag_z == ez, "R8 bit-clear flag", 64'(flag_z), 64'(ez));
        else             chk(flag_z == ez, "R10 zero flag", 64'(flag_z), 64'(ez));
        chk(mem_arr[widx] == exp_word, (op == 6) ? "R9 memory image" : "R2 memory image",
            mem_arr[widx], exp_word);
        chk(rd_cnt == 1 && wr_cnt == int'(wr), "R7 access count",
            64'(rd_cnt * 16 + wr_cnt), 64'(16 + int'(wr)));
        chk(!mem_lock && !align_err, "R5 lock released", 64'({mem_lock, align_err}), 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n       = 1'b0;
        op_valid    = 1'b0;
        op_code     = '0;
        op_size     = '0;
        op_addr     = '0;
        op_src      = '0;
        op_cmp      = '0;
        drain_empty = 1'b1;
        lat         = 0;
        exp_waddr   = '0;
        exp_be      = '0;
        for (int i = 0; i < 16; i++) mem_arr[i] = '0;
        repeat (3) @(negedge clk);
        chk(op_ready && !mem_req && !mem_lock && !done, "R1 reset state",
            64'({op_ready, mem_req, mem_lock, done}), 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(op_ready && !mem_req && !mem_lock && !done, "R1 idle after reset",
            64'({op_ready, mem_req, mem_lock, done}), 64'h8);

        // sweep: every operation, width, aligned offset and three data patterns
        n = 1;
        for (int op = 0; op < 8; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int off = 0; off < 8; off += (1 << sz))
                    for (int p = 0; p < 3; p++) begin
                        run_rmw(n, op, sz, off, p, 0);
                        n++;
                    end

        // barrier: hold drain_empty low across several cycles
        for (int op = 0; op < 8; op++) begin
            run_rmw(n, op, 3, 0, op % 3, 4 + op);
            n++;
        end

        // misaligned requests
        for (int sz = 1; sz < 4; sz++)
            for (int off = 1; off < 8; off++)
                if ((off % (1 << sz)) != 0) begin
                    logic [63:0] keep;
                    keep = mem_arr[2];
                    rd_cnt = 0;
                    wr_cnt = 0;
                    @(negedge clk);
                    op_code  = 3'd0;
                    op_size  = 2'(sz);
                    op_addr  = 16'(16 + off);
                    op_src   = 64'd1;
                    op_cmp   = 64'd0;
                    op_valid = 1'b1;
                    @(negedge clk);
                    op_valid = 1'b0;
                    chk(done && align_err && !mem_req, "R11 fault at once",
                        64'({done, align_err, mem_req}), 64'h6);
                    @(negedge clk);
                    chk(rd_cnt == 0 && wr_cnt == 0 && mem_arr[2] == keep, "R11 no bus cycle",
                        64'(rd_cnt + wr_cnt), 64'd0);
                end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule